// File: doc/BRIEF.md
# Shopping Cart Total Accumulator

This block keeps the running bill of a shopping cart. A small tagged table holds sixteen entries. Each entry is a 14-bit value plus a kind bit that says whether the value is an item price or a coupon amount. The table is indexed by a 4-bit item code. A 3-bit operation code on the shared input pins picks the action for the cycle: write a table entry, add an item, take an item back out, redeem a coupon, or check out with a tax percentage.

One 14-bit add/subtract unit serves add, remove and coupon. A 14x7 multiplier scales the total at checkout by a factor of 100 plus the tax percentage. The checkout result is therefore in hundredths of a cent: shifting the decimal point two places gives cents, and four places gives dollars.

Each lookup operation first reads the table into a registered last-value output. The total changes one cycle after that. A new operation may start on every cycle.

Top module: `cart_total`

## Requirements
- R1: While reset is low, last_value_o, total_o, bill_o and err_o read 0. After reset, every table entry holds value 0 with kind bit 0 (price).
- R2: Opcode 1 (load) writes wr_value_i, with wr_coupon_i as the kind bit (1 = coupon, 0 = price), into the entry at code_i. It changes none of the outputs. A lookup of that code on the very next cycle sees the new entry.
- R3: For opcodes 2, 3 and 4, last_value_o shows the value of the entry at code_i after the next rising edge. total_o and err_o show the result one edge later.
- R4: Opcode 2 (add) adds the value of a price entry to the total.
- R5: Opcode 3 (remove) subtracts the value of a price entry from the total. Opcode 4 (coupon) subtracts the value of a coupon entry from the total.
- R6: A remove or coupon whose value is larger than the total sets the total to 0 and sets err_o to 1.
- R7: An add whose sum is larger than 16383 sets the total to 16383 and sets err_o to 1.
- R8: An add or remove that hits a coupon entry, or a coupon that hits a price entry, leaves the total unchanged and sets err_o to 1.
- R9: Opcode 5 (checkout) sets bill_o to total x (100 + tax_pct_i) two edges after the opcode. It clears err_o and leaves total_o unchanged.
- R10: A checkout with tax_pct_i above 27, which would give a factor above 127, leaves bill_o unchanged and sets err_o to 1.
- R11: err_o is rewritten only by a completed add, remove, coupon or checkout, and a successful one clears it. Opcodes 0, 6 and 7 are idle. Idle and load change neither total_o, bill_o, err_o nor last_value_o.
- R12: Operations issued on consecutive cycles each take effect in issue order, with no lost or repeated update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation code: 0 idle, 1 load, 2 add, 3 remove, 4 coupon, 5 checkout, 6 and 7 idle |
| code_i | input | 4 | Item code, the table index |
| wr_value_i | input | 14 | Value written by load |
| wr_coupon_i | input | 1 | Kind bit written by load (1 = coupon) |
| tax_pct_i | input | 7 | Tax percentage used by checkout |
| last_value_o | output | 14 | Most recently looked-up entry value |
| total_o | output | 14 | Running cart total |
| bill_o | output | 21 | Last checkout result, total x (100 + percentage) |
| err_o | output | 1 | Status of the last completed arithmetic operation |

## Verification
The embedded properties assume that op_i, code_i and tax_pct_i carry known values that are stable around each rising edge. They also assume that only one operation reaches the update stage per cycle, so each property can compare the total with its value one edge earlier. The stimulus changes inputs only on the falling edge and issues at most one opcode per cycle. It keeps within the defined fields, except where it deliberately uses undefined opcodes and a tax percentage above 27 to exercise R10 and R11.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int CART_CODE_W = 4;
  localparam int CART_VAL_W  = 14;
  localparam int CART_TAX_W  = 7;
  localparam int CART_TAX_BASE = 100;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_LOAD     = 3'd1,
    OP_ADD      = 3'd2,
    OP_REMOVE   = 3'd3,
    OP_COUPON   = 3'd4,
    OP_CHECKOUT = 3'd5
  } cart_op_e;

  typedef struct packed {
    logic                  coupon;
    logic [CART_VAL_W-1:0] value;
  } cart_entry_t;
endpackage

// File: rtl/cart_table.sv
module cart_table
  import cart_pkg::*;
#(
  parameter int CODE_W = CART_CODE_W,
  parameter int VAL_W  = CART_VAL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              we_i,
  input  logic [VAL_W-1:0]  wr_value_i,
  input  logic              wr_coupon_i,
  input  logic              rd_en_i,
  output logic [VAL_W-1:0]  rd_value_o,
  output logic              rd_coupon_o
);
  localparam int DEPTH   = 1 << CODE_W;
  localparam int ENTRY_W = VAL_W + 1;

  logic [DEPTH-1:0][ENTRY_W-1:0] mem_q, mem_d;
  logic [ENTRY_W-1:0]            rd_q, rd_d;

  always_comb begin
    mem_d = mem_q;
    if (we_i) mem_d[code_i] = {wr_coupon_i, wr_value_i};
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en_i) rd_d = mem_q[code_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      rd_q  <= '0;
    end else begin
      mem_q <= mem_d;
      rd_q  <= rd_d;
    end
  end

  assign rd_coupon_o = rd_q[ENTRY_W-1];
  assign rd_value_o  = rd_q[VAL_W-1:0];

  // R2
  write_only_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/cart_addsub.sv
module cart_addsub #(
  parameter int W = 14
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] wide;
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = b_i ^ {W{cin_i}};
    wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  end

  assign sum_o  = wide[W-1:0];
  assign cout_o = wide[W];
endmodule

// File: rtl/cart_mult.sv
module cart_mult #(
  parameter int A_W = 14,
  parameter int B_W = 7
) (
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic [A_W+B_W-1:0] p_o
);
  localparam int P_W = A_W + B_W;

  logic [B_W-1:0][P_W-1:0] pp;

  for (genvar i = 0; i < B_W; i++) begin : g_pp
    assign pp[i] = b_i[i] ? (P_W'(a_i) << i) : '0;
  end

  always_comb begin
    p_o = '0;
    for (int k = 0; k < B_W; k++) p_o = p_o + pp[k];
  end
endmodule

// File: rtl/cart_total.sv
module cart_total
  import cart_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [2:0]                       op_i,
  input  logic [CART_CODE_W-1:0]           code_i,
  input  logic [CART_VAL_W-1:0]            wr_value_i,
  input  logic                             wr_coupon_i,
  input  logic [CART_TAX_W-1:0]            tax_pct_i,
  output logic [CART_VAL_W-1:0]            last_value_o,
  output logic [CART_VAL_W-1:0]            total_o,
  output logic [CART_VAL_W+CART_TAX_W-1:0] bill_o,
  output logic                             err_o
);
  localparam int VAL_W    = CART_VAL_W;
  localparam int TAX_W    = CART_TAX_W;
  localparam int FACT_W   = TAX_W + 1;
  localparam int PROD_W   = VAL_W + TAX_W;
  localparam logic [VAL_W-1:0]  VAL_MAX  = '1;
  localparam logic [FACT_W-1:0] FACT_MAX = FACT_W'((1 << TAX_W) - 1);
  localparam logic [FACT_W-1:0] FACT_BASE = FACT_W'(CART_TAX_BASE);

  // reset synchronizer: assert asynchronously, release on clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // stage 1: decode and table lookup
  cart_op_e          dec_op;
  logic              is_lookup;
  logic              tbl_we;
  logic [FACT_W-1:0] fact_d;

  always_comb begin
    case (op_i)
      3'd1:    dec_op = OP_LOAD;
      3'd2:    dec_op = OP_ADD;
      3'd3:    dec_op = OP_REMOVE;
      3'd4:    dec_op = OP_COUPON;
      3'd5:    dec_op = OP_CHECKOUT;
      default: dec_op = OP_IDLE;
    endcase
    is_lookup = (dec_op == OP_ADD) || (dec_op == OP_REMOVE) || (dec_op == OP_COUPON);
    tbl_we    = (dec_op == OP_LOAD);
    fact_d    = {1'b0, tax_pct_i} + FACT_BASE;
  end

  logic [VAL_W-1:0] look_value;
  logic             look_cpn;

  cart_table #(.CODE_W(CART_CODE_W), .VAL_W(VAL_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .code_i      (code_i),
    .we_i        (tbl_we),
    .wr_value_i  (wr_value_i),
    .wr_coupon_i (wr_coupon_i),
    .rd_en_i     (is_lookup),
    .rd_value_o  (look_value),
    .rd_coupon_o (look_cpn)
  );

  cart_op_e          s1_op_q, s1_op_d;
  logic [FACT_W-1:0] s1_fact_q, s1_fact_d;

  always_comb begin
    s1_op_d   = dec_op;
    s1_fact_d = s1_fact_q;
    if (dec_op == OP_CHECKOUT) s1_fact_d = fact_d;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_op_q   <= OP_IDLE;
      s1_fact_q <= '0;
    end else begin
      s1_op_q   <= s1_op_d;
      s1_fact_q <= s1_fact_d;
    end
  end

  // stage 2: arithmetic and total update
  logic [VAL_W-1:0]  total_q, total_d;
  logic [PROD_W-1:0] bill_q, bill_d;
  logic              err_q, err_d;
  logic [VAL_W-1:0]  as_sum;
  logic              as_cout;
  logic              as_sub;
  logic [PROD_W-1:0] prod;

  assign as_sub = (s1_op_q != OP_ADD);

  cart_addsub #(.W(VAL_W)) u_addsub (
    .a_i    (total_q),
    .b_i    (look_value),
    .cin_i  (as_sub),
    .sum_o  (as_sum),
    .cout_o (as_cout)
  );

  cart_mult #(.A_W(VAL_W), .B_W(TAX_W)) u_mult (
    .a_i (total_q),
    .b_i (s1_fact_q[TAX_W-1:0]),
    .p_o (prod)
  );

  always_comb begin
    total_d = total_q;
    bill_d  = bill_q;
    err_d   = err_q;
    case (s1_op_q)
      OP_ADD: begin
        if (look_cpn) begin
          err_d = 1'b1;
        end else if (as_cout) begin
          total_d = VAL_MAX;
          err_d   = 1'b1;
        end else begin
          total_d = as_sum;
          err_d   = 1'b0;
        end
      end
      OP_REMOVE, OP_COUPON: begin
        if ((s1_op_q == OP_COUPON) != look_cpn) begin
          err_d = 1'b1;
        end else if (!as_cout) begin
          total_d = '0;
          err_d   = 1'b1;
        end else begin
          total_d = as_sum;
          err_d   = 1'b0;
        end
      end
      OP_CHECKOUT: begin
        if (s1_fact_q > FACT_MAX) begin
          err_d = 1'b1;
        end else begin
          bill_d = prod;
          err_d  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      total_q <= '0;
      bill_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      total_q <= total_d;
      bill_q  <= bill_d;
      err_q   <= err_d;
    end
  end

  assign last_value_o = look_value;
  assign total_o      = total_q;
  assign bill_o       = bill_q;
  assign err_o        = err_q;

  // R8
  kind_mismatch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (((s1_op_q == OP_ADD) || (s1_op_q == OP_REMOVE)) && look_cpn) ||
    ((s1_op_q == OP_COUPON) && !look_cpn)
    |=> $stable(total_q) && err_q);

  // R4
  add_no_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (s1_op_q == OP_ADD) |=> total_q >= $past(total_q));

  // R6
  subtract_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((s1_op_q == OP_REMOVE) || (s1_op_q == OP_COUPON)) |=> total_q <= $past(total_q));

  // R9
  checkout_keeps_total_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (s1_op_q == OP_CHECKOUT) |=> $stable(total_q));

  // R11
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ((s1_op_q == OP_IDLE) || (s1_op_q == OP_LOAD))
    |=> $stable(total_q) && $stable(err_q) && $stable(bill_q));
endmodule

// File: tb/sim_cart_total.sv
`timescale 1ns/1ps
module sim_cart_total;
  logic        clk;
  logic        rst_n;
  logic [2:0]  op;
  logic [3:0]  code;
  logic [13:0] wr_value;
  logic        wr_coupon;
  logic [6:0]  tax_pct;
  logic [13:0] last_value;
  logic [13:0] total;
  logic [20:0] bill;
  logic        err;

  cart_total u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .code_i(code),
    .wr_value_i(wr_value), .wr_coupon_i(wr_coupon), .tax_pct_i(tax_pct),
    .last_value_o(last_value), .total_o(total), .bill_o(bill), .err_o(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    int    kind;
    int    exp;
    string tag;
  } item_t;

  item_t sb[$];
  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  int m_val [16];
  bit m_cpn [16];
  int m_last = 0, m_total = 0, m_bill = 0, m_err = 0;

  function automatic int observe(int kind);
    case (kind)
      0: return int'(last_value);
      1: return int'(total);
      2: return int'(bill);
      default: return int'(err);
    endcase
  endfunction

  function automatic void check(string tag, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endfunction

  // monitor: pop every item due this cycle and compare
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      case (it.kind)
        0: check(it.tag, "last_value", observe(0), it.exp);
        1: check(it.tag, "total", observe(1), it.exp);
        2: check(it.tag, "bill", observe(2), it.exp);
        default: check(it.tag, "err", observe(3), it.exp);
      endcase
    end
  end

  function automatic void push(int due, int kind, int exp, string tag);
    item_t it;
    it.due = due; it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endfunction

  task automatic do_op(input int opc, input int c, input int v, input bit cp,
                       input int pct, input string tag);
    int fact;
    @(negedge clk);
    op = 3'(opc); code = 4'(c); wr_value = 14'(v); wr_coupon = cp; tax_pct = 7'(pct);
    case (opc)
      1: begin m_val[c] = v; m_cpn[c] = cp; end
      2: begin
        m_last = m_val[c];
        if (m_cpn[c]) m_err = 1;
        else if (m_total + m_val[c] > 16383) begin m_total = 16383; m_err = 1; end
        else begin m_total = m_total + m_val[c]; m_err = 0; end
      end
      3, 4: begin
        m_last = m_val[c];
        if (m_cpn[c] != (opc == 4)) m_err = 1;
        else if (m_val[c] > m_total) begin m_total = 0; m_err = 1; end
        else begin m_total = m_total - m_val[c]; m_err = 0; end
      end
      5: begin
        fact = 100 + pct;
        if (fact > 127) m_err = 1;
        else begin m_bill = m_total * fact; m_err = 0; end
      end
      default: ;
    endcase
    push(cyc + 1, 0, m_last, tag);
    push(cyc + 2, 1, m_total, tag);
    push(cyc + 2, 2, m_bill, tag);
    push(cyc + 2, 3, m_err, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_cpn[i] = 0; end
    op = 3'd0; code = '0; wr_value = '0; wr_coupon = 1'b0; tax_pct = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "last_value", int'(last_value), 0);
    check("R1", "total", int'(total), 0);
    check("R1", "bill", int'(bill), 0);
    check("R1", "err", int'(err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    do_op(2, 5, 0, 0, 0, "R1 cleared table");
    // R2 table loads
    do_op(1, 8, 500, 0, 0, "R2 load");
    do_op(1, 10, 750, 0, 0, "R2 load");
    do_op(1, 0, 20, 1, 0, "R2 load");
    do_op(1, 3, 900, 0, 0, "R2 load");
    do_op(1, 15, 16000, 0, 0, "R2 load");
    do_op(1, 7, 9000, 1, 0, "R2 load");
    // R3 R4 R12 back-to-back adds
    do_op(2, 8, 0, 0, 0, "R4 add");
    do_op(2, 10, 0, 0, 0, "R12 add");
    do_op(2, 3, 0, 0, 0, "R3 add");
    // R5 remove and coupon
    do_op(3, 10, 0, 0, 0, "R5 remove");
    do_op(4, 0, 0, 0, 0, "R5 coupon");
    // R9 checkout
    do_op(5, 0, 0, 0, 3, "R9 checkout");
    // R8 kind mismatches
    do_op(4, 8, 0, 0, 0, "R8 coupon on price");
    do_op(2, 0, 0, 0, 0, "R8 add on coupon");
    do_op(3, 7, 0, 0, 0, "R8 remove on coupon");
    // R11 idle and undefined opcodes
    do_op(0, 8, 0, 0, 0, "R11 idle");
    do_op(6, 3, 0, 0, 0, "R11 op6");
    do_op(7, 10, 0, 0, 0, "R11 op7");
    // R10 out-of-range tax
    do_op(5, 0, 0, 0, 30, "R10 tax range");
    // R7 overflow then largest checkout
    do_op(2, 15, 0, 0, 0, "R7 overflow");
    do_op(5, 0, 0, 0, 27, "R9 max factor");
    do_op(4, 7, 0, 0, 0, "R5 coupon large");
    // R6 underflow
    do_op(3, 15, 0, 0, 0, "R6 underflow");
    do_op(4, 7, 0, 0, 0, "R6 coupon underflow");
    do_op(2, 8, 0, 0, 0, "R4 add after error");
    // R2 write then immediate read
    do_op(1, 8, 100, 0, 0, "R2 overwrite");
    do_op(2, 8, 0, 0, 0, "R2 read new entry");
    do_op(3, 8, 0, 0, 0, "R5 remove exact");
    do_op(5, 0, 0, 0, 0, "R9 zero tax");
    do_op(3, 3, 0, 0, 0, "R6 remove to floor");
    repeat (4) do_op(0, 0, 0, 0, 0, "R11 drain");
    while (sb.size() > 0) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 5000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule